// File: doc/BRIEF.md
# Serial/Parallel Shift Register with Sign Extension

This block is an eight-bit register that performs one of four operations on each rising clock edge. It can keep its contents, take a word from a shared parallel port, shift right with a new top bit taken from one of two serial inputs, or shift right arithmetically so that the top bit stays in place and is copied downward. An active-low reset clears the register at once, without waiting for the clock.

The parallel port serves as both input and output. Here it is split into a data-in bus, a data-out bus and a drive flag, which pad logic outside the block turns into a three-state pin. The drive flag is low while the block loads from the port and while the active-low output enable is high. The lowest register bit is always available on a separate serial output. Typical uses are serial-to-parallel conversion and the repeated arithmetic halving steps of a shift-and-add multiplier.

Top module: `sgnshift_reg`

## Requirements
- R1: With `rstN` low the register reads all zeros, and this takes effect between clock edges without waiting for the next rising edge.
- R2: When `regEnN` is 1, a rising edge leaves the register unchanged, whatever the other control inputs are.
- R3: When `regEnN` is 0 and `shiftNotLoad` is 0, a rising edge copies `parIn` into the register.
- R4: When `regEnN` is 0 and `shiftNotLoad` is 1, a rising edge shifts right: each new bit n (n from 0 to 6) equals old bit n+1.
- R5: During a right shift with `sextN` at 1, the new bit 7 comes from `serIn0` when `serSel` is 0 and from `serIn1` when `serSel` is 1.
- R6: During a right shift with `sextN` at 0, bit 7 keeps its old value, so a negative value stays negative (an arithmetic right shift).
- R7: `parDrive` is 1 only when `outEnN` is 0 and the block is not in parallel-load mode. `parOut` equals the register when `parDrive` is 1 and reads all zeros otherwise.
- R8: `serOut` always equals register bit 0, whatever the value of `outEnN`.
- R9: With `outEnN` at 1, loading and shifting still change the register exactly as in R3 to R6.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; operations happen on the rising edge |
| rstN | input | 1 | Asynchronous clear, active low |
| regEnN | input | 1 | Operation enable, active low; high holds |
| shiftNotLoad | input | 1 | 1 = shift right, 0 = parallel load |
| sextN | input | 1 | Active-low sign extension during a shift |
| serSel | input | 1 | Serial source select: 0 = serIn0, 1 = serIn1 |
| serIn0 | input | 1 | Serial data input 0 |
| serIn1 | input | 1 | Serial data input 1 |
| outEnN | input | 1 | Parallel output enable, active low |
| parIn | input | 8 | Parallel load data from the shared port |
| parOut | output | 8 | Parallel output data (zero when not driving) |
| parDrive | output | 1 | Port drive enable for pad logic |
| serOut | output | 1 | Register bit 0 |

## Verification
The bench steps through every combination of the five control inputs and the four serial-input pairs, starting from several seed words. Sparse, dense and alternating seeds show whether each bit moves by exactly one place and whether bit 7 takes the serial bit, keeps its old value or takes the port value. After each step the bench holds the register and enables the output so that the whole word can be read through the port. This shows that the output enable had no effect on the update. A negative word that is shifted four times with sign extension is compared with the arithmetic quotient. A reset asserted in the middle of a clock cycle must clear the outputs before the next edge.

// File: rtl/sgnshift_pkg.sv
`timescale 1ns/1ps
package sgnshift_pkg;
  // Strobes passed from the control decode to the datapath
  typedef struct packed {
    logic hold;    // keep contents
    logic load;    // take the parallel port
    logic shift;   // move right by one place
    logic extend;  // bit 7 keeps its value during a shift
    logic serBit;  // selected serial entry bit
  } strobes_t;
endpackage

// File: rtl/sgnshift_ctrl.sv
`timescale 1ns/1ps
module sgnshift_ctrl
  import sgnshift_pkg::*;
(
  input  logic     regEnN,
  input  logic     shiftNotLoad,
  input  logic     sextN,
  input  logic     serSel,
  input  logic     serIn0,
  input  logic     serIn1,
  input  logic     outEnN,
  output strobes_t stb,
  output logic     parDrive
);
  logic loadMode;

  // Decode priority: hold wins, then load, then shift
  always_comb begin
    loadMode   = !regEnN && !shiftNotLoad;
    stb.hold   = regEnN;
    stb.load   = loadMode;
    stb.shift  = !regEnN && shiftNotLoad;
    stb.extend = !sextN;
    stb.serBit = serSel ? serIn1 : serIn0;
    parDrive   = !outEnN && !loadMode;
  end

  // At most one operation is selected at a time
  always_comb begin
    p_one_op_r2: assert ($onehot0({stb.hold, stb.load, stb.shift}));
  end
endmodule

// File: rtl/sgnshift_datapath.sv
`timescale 1ns/1ps
module sgnshift_datapath
  import sgnshift_pkg::*;
#(
  parameter int WIDTH = 8
) (
  input  logic             clk,
  input  logic             rstN,
  input  strobes_t         stb,
  input  logic [WIDTH-1:0] parIn,
  output logic [WIDTH-1:0] regQ
);
  localparam int TOP = WIDTH - 1;

  logic [WIDTH-1:0] nextQ;

  // One cell per bit; the top cell picks serial entry or its own value
  for (genvar i = 0; i < WIDTH; i++) begin : g_cell
    if (i == TOP) begin : g_top
      assign nextQ[i] = stb.load  ? parIn[i] :
                        stb.shift ? (stb.extend ? regQ[i] : stb.serBit) :
                                    regQ[i];
    end else begin : g_low
      assign nextQ[i] = stb.load  ? parIn[i] :
                        stb.shift ? regQ[i+1] :
                                    regQ[i];
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) regQ <= '0;
    else       regQ <= nextQ;
  end

  p_hold_r2: assert property (@(posedge clk) disable iff (!rstN)
    stb.hold |=> $stable(regQ));
  p_load_r3: assert property (@(posedge clk) disable iff (!rstN)
    stb.load |=> regQ == $past(parIn));
  p_shift_r4: assert property (@(posedge clk) disable iff (!rstN)
    stb.shift |=> regQ[TOP-1:0] == $past(regQ[TOP:1]));
  p_sext_r6: assert property (@(posedge clk) disable iff (!rstN)
    (stb.shift && stb.extend) |=> regQ[TOP] == $past(regQ[TOP]));
endmodule

// File: rtl/sgnshift_reg.sv
`timescale 1ns/1ps
module sgnshift_reg
  import sgnshift_pkg::*;
#(
  parameter int WIDTH = 8
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             regEnN,
  input  logic             shiftNotLoad,
  input  logic             sextN,
  input  logic             serSel,
  input  logic             serIn0,
  input  logic             serIn1,
  input  logic             outEnN,
  input  logic [WIDTH-1:0] parIn,
  output logic [WIDTH-1:0] parOut,
  output logic             parDrive,
  output logic             serOut
);
  strobes_t         stb;
  logic [WIDTH-1:0] regQ;

  sgnshift_ctrl ctrl_i (
    .regEnN(regEnN), .shiftNotLoad(shiftNotLoad), .sextN(sextN),
    .serSel(serSel), .serIn0(serIn0), .serIn1(serIn1), .outEnN(outEnN),
    .stb(stb), .parDrive(parDrive)
  );

  sgnshift_datapath #(.WIDTH(WIDTH)) dp_i (
    .clk(clk), .rstN(rstN), .stb(stb), .parIn(parIn), .regQ(regQ)
  );

  assign parOut = parDrive ? regQ : '0;
  assign serOut = regQ[0];

  p_serial_r5: assert property (@(posedge clk) disable iff (!rstN)
    (!regEnN && shiftNotLoad && sextN) |=>
      regQ[WIDTH-1] == $past(serSel ? serIn1 : serIn0));
  p_drive_r7: assert property (@(posedge clk) disable iff (!rstN)
    (outEnN || (!regEnN && !shiftNotLoad)) |-> !parDrive);
endmodule

// File: tb/sgnshift_reg_tb_top.sv
`timescale 1ns/1ps
module sgnshift_reg_tb_top;
  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       regEnN = 1'b1, shiftNotLoad = 1'b0, sextN = 1'b1, serSel = 1'b0;
  logic       serIn0 = 1'b0, serIn1 = 1'b0, outEnN = 1'b0;
  logic [7:0] parIn = '0;
  logic [7:0] parOut;
  logic       parDrive, serOut;

  int         nChecks = 0;
  int         nFails  = 0;
  logic [7:0] model   = '0;

  always #4 clk = ~clk;  // 125 MHz

  sgnshift_reg dut_i (
    .clk(clk), .rstN(rstN), .regEnN(regEnN), .shiftNotLoad(shiftNotLoad),
    .sextN(sextN), .serSel(serSel), .serIn0(serIn0), .serIn1(serIn1),
    .outEnN(outEnN), .parIn(parIn), .parOut(parOut), .parDrive(parDrive),
    .serOut(serOut)
  );

  task automatic chk(input bit ok, input string req, input logic [7:0] act,
                     input logic [7:0] exp);
    nChecks++;
    if (!ok) begin
      nFails++;
      $display("FAIL %s actual=%h expected=%h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic finishRun();
    $display("%0d/%0d checks passed", nChecks - nFails, nChecks);
    $finish;
  endtask

  // Hold the register and enable the port, then compare the whole word
  task automatic peek(input string req);
    regEnN = 1'b1;
    outEnN = 1'b0;
    #1;
    chk(parOut == model, req, parOut, model);
    chk(serOut == model[0], "R8", {7'b0, serOut}, {7'b0, model[0]});
  endtask

  task automatic step(input logic en, input logic sp, input logic se,
                      input logic sel, input logic s0, input logic s1,
                      input logic oe, input logic [7:0] pin);
    logic       expDrive;
    logic [7:0] nxt;
    string      tag;
    @(negedge clk);
    regEnN = en; shiftNotLoad = sp; sextN = se; serSel = sel;
    serIn0 = s0; serIn1 = s1; outEnN = oe; parIn = pin;
    #1;
    expDrive = !oe && !(!en && !sp);
    chk(parDrive == expDrive, "R7", {7'b0, parDrive}, {7'b0, expDrive});
    chk(parOut == (expDrive ? model : 8'h00), "R7", parOut,
        expDrive ? model : 8'h00);
    chk(serOut == model[0], "R8", {7'b0, serOut}, {7'b0, model[0]});
    if (en) begin
      nxt = model; tag = "R2";
    end else if (!sp) begin
      nxt = pin; tag = oe ? "R3 R9" : "R3";
    end else if (se) begin
      nxt = {sel ? s1 : s0, model[7:1]}; tag = oe ? "R4 R5 R9" : "R4 R5";
    end else begin
      nxt = {model[7], model[7:1]}; tag = oe ? "R4 R6 R9" : "R4 R6";
    end
    @(posedge clk);
    @(negedge clk);
    model = nxt;
    peek(tag);
  endtask

  initial begin
    #(8 * 200000);
    nFails++;
    nChecks++;
    $display("FAIL watchdog expired");
    finishRun();
  end

  initial begin
    logic [7:0] seeds [0:5];
    seeds[0] = 8'h00; seeds[1] = 8'hFF; seeds[2] = 8'hA5;
    seeds[3] = 8'h5A; seeds[4] = 8'h81; seeds[5] = 8'h10;

    // Reset state (R1)
    #3;
    chk(parOut == 8'h00, "R1", parOut, 8'h00);
    chk(serOut == 1'b0, "R1", {7'b0, serOut}, 8'h00);
    @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    peek("R1");

    // Sweep: seed load, then every control combination with every serial pair
    for (int s = 0; s < 6; s++) begin
      for (int c = 0; c < 32; c++) begin
        for (int p = 0; p < 4; p++) begin
          step(1'b0, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, seeds[s] ^ 8'(c * 7 + p));
          step(c[0], c[1], c[2], c[3], p[0], p[1], c[4], ~seeds[s] ^ 8'(c));
        end
      end
    end

    // Arithmetic shift of a negative value (R6)
    step(1'b0, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 8'h90);
    for (int k = 0; k < 4; k++)
      step(1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 1'b1, 1'b1, 8'h00);
    begin
      logic [7:0] q;
      q = 8'($signed(8'h90) >>> 4);
      chk(model == q, "R6", model, q);
      chk(parOut == q, "R6", parOut, q);
    end

    // Reset in the middle of a cycle (R1)
    step(1'b0, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 8'hA7);
    @(posedge clk);
    #2;
    rstN = 1'b0;
    #1;
    chk(parOut == 8'h00, "R1", parOut, 8'h00);
    chk(serOut == 1'b0, "R1", {7'b0, serOut}, 8'h00);
    model = 8'h00;
    @(negedge clk);
    rstN = 1'b1;
    peek("R1");

    finishRun();
  end
endmodule